// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits between a host's write strobes and a byte-wide flash array. It watches every bus write, with its address, data byte and one-hot sector-select lines, and recognises the multi-write unlock and command sequences that a standard parallel flash part accepts. When a sequence completes, it issues a single-cycle control pulse to the array's program and erase engine. The pulses cover: enter identifier mode, program byte, erase sectors, erase whole array, suspend, resume, reset, and enter or exit unlock bypass. Only the low `DEC_W` address bits take part in decoding.

The decoder also tracks the mode the device is in and reports it on `mode` and `busy`. In identifier mode it steers the read-data mux through `rd_sel`. A sector erase does not start at once. It opens a collection window in which more sectors may be added, and it starts only after `WIN_CYC` cycles pass with no new sector. The block then stays busy until the array reports `erase_done`.

States and transitions:
- **ST_READ**: AAh@555h goes to ST_UNL1.
- **ST_UNL1**: 55h@AAAh goes to ST_UNL2.
- **ST_UNL2**: the third write selects the command.
  - 90h@555h goes to ST_IDENT.
  - A0h@555h goes to ST_PGM_ARM.
  - 80h@555h goes to ST_ERS1.
  - 20h@555h goes to ST_BYP.
- **ST_PGM_ARM**: any write programs and returns to ST_READ.
- **ST_ERS1 / ST_ERS2**: ST_ERS1 expects AAh@555h and ST_ERS2 expects 55h@AAAh, leading to ST_ERS3.
- **ST_ERS3**: 10h@555h goes to ST_ERASING. 30h with a sector selected goes to ST_WINDOW.
- **ST_WINDOW**: the window expires into ST_ERASING.
- **ST_ERASING / ST_SUSP**: B0h moves ST_ERASING to ST_SUSP. 30h moves ST_SUSP back to ST_ERASING. `erase_done` moves ST_ERASING to ST_READ.
- **ST_IDENT**: F0h goes to ST_READ.
- **ST_BYP**: A0h goes to ST_BYP_ARM and 90h goes to ST_BYP_EXIT.
- **ST_BYP_ARM**: any write programs and returns to ST_BYP.
- **ST_BYP_EXIT**: 00h goes to ST_READ. Anything else goes back to ST_BYP.

Top module: `flash_cmd_decoder`

## Requirements
- R1: A command sequence starts with AAh written to low address 555h, then 55h written to low address AAAh. Any write in the read-based sequence states (ST_UNL1, ST_UNL2, ST_ERS1..3) that is not the expected next step returns to read mode (`mode`=0) and issues no pulse.
- R2: Only address bits [DEC_W-1:0] (default 11:0) are compared. Upper address bits never change the decode.
- R3: A third write of 90h@555h pulses `id_enter_p` and sets `mode`=1. In that mode, `rd_sel` is 1 (device ID) when read address bits (A6,A1,A0)=(0,0,1), 2 (protection status) when they are (0,1,0), and 0 (array) otherwise. In any other mode `rd_sel` is 0. Writes other than F0h are ignored in identifier mode.
- R4: A third write of A0h@555h arms programming. The next write of any value pulses `prog_p` and presents that write's full address on `prog_addr` and its data on `prog_data`.
- R5: The sequence AAh@555h, 55h@AAAh, 80h@555h, AAh@555h, 55h@AAAh, 10h@555h pulses `bulk_erase_p` and sets `busy`=1 with `mode`=3.
- R6: In the same sequence, a final 30h write opens the sector window only if at least one `sect_sel` bit is high. With `sect_sel`=0 the sequence aborts to read mode with no pulse.
- R7: While the window is open (`mode`=3, `busy`=0), each 30h write with a sector selected ORs `sect_sel` into the sector mask and restarts the window. All other writes are ignored. `sect_erase_p` pulses exactly `WIN_CYC` cycles after the last accepted 30h write, with the mask on `erase_sectors`, and `busy` rises.
- R8: `busy` stays high, with `mode`=3 or 4, until `erase_done` is seen in the erasing state. The decoder then returns to read mode.
- R9: During a sector erase, B0h at any address pulses `suspend_p` and sets `mode`=4. Then 30h at any address pulses `resume_p` and sets `mode`=3. During a bulk erase, B0h has no effect.
- R10: F0h at any address pulses `reset_p` and returns to read mode from read mode, identifier mode, or any read-based sequence step. It is not a reset in bypass or erase modes.
- R11: A third write of 20h@555h pulses `byp_enter_p` and sets `mode`=2. In bypass mode, A0h at any address followed by any write pulses `prog_p` with that write's address and data.
- R12: Bypass mode is left only by 90h then 00h, both at any address, which pulses `byp_exit_p`. A write other than 00h after the 90h returns to bypass.
- R13: Every pulse is high for exactly the one cycle after the clock edge that sampled the completing write, or that ended the window. At most one pulse is high at a time. Pulse bit order used by the checks is {id_enter, prog, sect_erase, bulk_erase, suspend, resume, reset, byp_enter, byp_exit}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | One bus write is sampled on each clock edge where this is high |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data byte |
| sect_sel | input | N_SECT | Active-high sector selects for the write address |
| erase_done | input | 1 | Array reports that the running erase has finished |
| rd_addr | input | ADDR_W | Current read address |
| rd_sel | output | 2 | Read mux select: 0 array, 1 device ID, 2 protection status |
| id_enter_p | output | 1 | Pulse: identifier mode entered |
| prog_p | output | 1 | Pulse: program one byte |
| prog_addr | output | ADDR_W | Address to program, valid with prog_p |
| prog_data | output | 8 | Byte to program, valid with prog_p |
| sect_erase_p | output | 1 | Pulse: erase the sectors in erase_sectors |
| erase_sectors | output | N_SECT | Collected sector mask |
| bulk_erase_p | output | 1 | Pulse: erase the whole array |
| suspend_p | output | 1 | Pulse: suspend the sector erase |
| resume_p | output | 1 | Pulse: resume the sector erase |
| reset_p | output | 1 | Pulse: return to read mode |
| byp_enter_p | output | 1 | Pulse: unlock bypass entered |
| byp_exit_p | output | 1 | Pulse: unlock bypass left |
| mode | output | 3 | 0 read, 1 identifier, 2 bypass, 3 erase, 4 erase suspended |
| busy | output | 1 | An erase has started and erase_done has not been seen |

## Verification
Clean command sequences show that each command produces exactly its own pulse and mode. Sequences broken by one wrong address or wrong data byte show that aborts return to the base state without a pulse. Writes with random upper address bits show that only the low bits are decoded.

The sector window is exercised in three ways: a single sector, a second sector added mid-window with an ignored write in between, and a final write with no sector selected. The cycle-exact position of `sect_erase_p` then separates a correct restart from a missed or early expiry. Suspend is tried during a sector erase and again during a bulk erase.

A long constrained-random stream draws from unlock, command, reset, bypass and junk writes. Each pulse and mode is compared with a bench model, which tests the interplay of identifier, bypass and program modes that directed tests do not reach.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

    typedef enum logic [3:0] {
        ST_READ,
        ST_UNL1,
        ST_UNL2,
        ST_PGM_ARM,
        ST_ERS1,
        ST_ERS2,
        ST_ERS3,
        ST_WINDOW,
        ST_ERASING,
        ST_SUSP,
        ST_IDENT,
        ST_BYP,
        ST_BYP_ARM,
        ST_BYP_EXIT
    } fcd_state_e;

    typedef enum logic [2:0] {
        MODE_READ   = 3'd0,
        MODE_IDENT  = 3'd1,
        MODE_BYPASS = 3'd2,
        MODE_ERASE  = 3'd3,
        MODE_SUSP   = 3'd4
    } fcd_mode_e;

    localparam logic [1:0] RSEL_ARRAY = 2'd0;
    localparam logic [1:0] RSEL_DEVID = 2'd1;
    localparam logic [1:0] RSEL_PROT  = 2'd2;

    // Command byte codes; index order matches fcd_match_t data fields
    localparam int N_CODES = 11;
    localparam logic [7:0] CODE_TAB [N_CODES] = '{
        8'hAA, 8'h55, 8'h90, 8'hA0, 8'h80, 8'h20,
        8'h10, 8'h30, 8'hB0, 8'hF0, 8'h00
    };

    typedef struct packed {
        logic at_555;
        logic at_aaa;
        logic haa;
        logic h55;
        logic h90;
        logic ha0;
        logic h80;
        logic h20;
        logic h10;
        logic h30;
        logic hb0;
        logic hf0;
        logic h00;
    } fcd_match_t;

    typedef struct packed {
        logic id_enter;
        logic prog;
        logic sect_erase;
        logic bulk_erase;
        logic suspend;
        logic resume;
        logic reset;
        logic byp_enter;
        logic byp_exit;
    } fcd_pulse_t;

endpackage

// File: rtl/fcd_match.sv
module fcd_match
    import fcd_pkg::*;
#(
    parameter int DEC_W = 12
) (
    input  logic [DEC_W-1:0] dec_addr,
    input  logic [7:0]       data,
    output fcd_match_t       mt
);

    localparam logic [DEC_W-1:0] ADDR_A = DEC_W'(12'h555);
    localparam logic [DEC_W-1:0] ADDR_B = DEC_W'(12'hAAA);

    logic [N_CODES-1:0] hit;

    for (genvar i = 0; i < N_CODES; i++) begin : g_code
        assign hit[i] = (data == CODE_TAB[i]);
    end

    always_comb begin
        mt.at_555 = (dec_addr == ADDR_A);
        mt.at_aaa = (dec_addr == ADDR_B);
        mt.haa    = hit[0];
        mt.h55    = hit[1];
        mt.h90    = hit[2];
        mt.ha0    = hit[3];
        mt.h80    = hit[4];
        mt.h20    = hit[5];
        mt.h10    = hit[6];
        mt.h30    = hit[7];
        mt.hb0    = hit[8];
        mt.hf0    = hit[9];
        mt.h00    = hit[10];
    end

endmodule

// File: rtl/fcd_window_timer.sv
module fcd_window_timer #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic expired
);

    localparam int CNT_W = (LIMIT < 2) ? 1 : $clog2(LIMIT);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

    logic [CNT_W-1:0] cnt_q;

    assign expired = (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (run && !expired) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/fcd_read_sel.sv
module fcd_read_sel
    import fcd_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic              ident,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [1:0]        rd_sel
);

    logic [2:0] key;
    logic       rd_unused;

    assign key       = {rd_addr[6], rd_addr[1], rd_addr[0]};
    assign rd_unused = ^{rd_addr[ADDR_W-1:7], rd_addr[5:2]};

    always_comb begin
        rd_sel = RSEL_ARRAY;
        if (ident) begin
            unique case (key)
                3'b001:  rd_sel = RSEL_DEVID;
                3'b010:  rd_sel = RSEL_PROT;
                default: rd_sel = RSEL_ARRAY;
            endcase
        end
    end

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import fcd_pkg::*;
#(
    parameter int ADDR_W  = 18,
    parameter int DEC_W   = 12,
    parameter int N_SECT  = 8,
    parameter int WIN_CYC = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [N_SECT-1:0] sect_sel,
    input  logic              erase_done,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [1:0]        rd_sel,
    output logic              id_enter_p,
    output logic              prog_p,
    output logic [ADDR_W-1:0] prog_addr,
    output logic [7:0]        prog_data,
    output logic              sect_erase_p,
    output logic [N_SECT-1:0] erase_sectors,
    output logic              bulk_erase_p,
    output logic              suspend_p,
    output logic              resume_p,
    output logic              reset_p,
    output logic              byp_enter_p,
    output logic              byp_exit_p,
    output logic [2:0]        mode,
    output logic              busy
);

    fcd_state_e        st_q, st_nxt;
    fcd_match_t        mt;
    fcd_pulse_t        pn, pulse_q;
    logic              sect_any;
    logic              mask_load, mask_or, win_clear, win_exp;
    logic              bulk_q;
    logic [N_SECT-1:0] mask_q;
    logic [ADDR_W-1:0] paddr_q;
    logic [7:0]        pdata_q;
    fcd_mode_e         mode_e;

    fcd_match #(.DEC_W(DEC_W)) u_match (
        .dec_addr (wr_addr[DEC_W-1:0]),
        .data     (wr_data),
        .mt       (mt)
    );

    fcd_window_timer #(.LIMIT(WIN_CYC)) u_win (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (win_clear),
        .run     (st_q == ST_WINDOW),
        .expired (win_exp)
    );

    fcd_read_sel #(.ADDR_W(ADDR_W)) u_rsel (
        .ident   (st_q == ST_IDENT),
        .rd_addr (rd_addr),
        .rd_sel  (rd_sel)
    );

    assign sect_any = |sect_sel;

    // Next state and next pulse
    always_comb begin
        st_nxt    = st_q;
        pn        = '0;
        mask_load = 1'b0;
        mask_or   = 1'b0;
        win_clear = 1'b0;
        unique case (st_q)
            ST_READ: begin
                if (wr_en) begin
                    if (mt.hf0)                   pn.reset = 1'b1;
                    else if (mt.haa && mt.at_555) st_nxt   = ST_UNL1;
                end
            end
            ST_UNL1: begin
                if (wr_en) begin
                    st_nxt = ST_READ;
                    if (mt.hf0)                   pn.reset = 1'b1;
                    else if (mt.h55 && mt.at_aaa) st_nxt   = ST_UNL2;
                end
            end
            ST_UNL2: begin
                if (wr_en) begin
                    st_nxt = ST_READ;
                    if (mt.hf0) begin
                        pn.reset = 1'b1;
                    end else if (mt.at_555) begin
                        if (mt.h90) begin
                            pn.id_enter = 1'b1;
                            st_nxt      = ST_IDENT;
                        end else if (mt.ha0) begin
                            st_nxt = ST_PGM_ARM;
                        end else if (mt.h80) begin
                            st_nxt = ST_ERS1;
                        end else if (mt.h20) begin
                            pn.byp_enter = 1'b1;
                            st_nxt       = ST_BYP;
                        end
                    end
                end
            end
            ST_PGM_ARM: begin
                if (wr_en) begin
                    pn.prog = 1'b1;
                    st_nxt  = ST_READ;
                end
            end
            ST_ERS1: begin
                if (wr_en) begin
                    st_nxt = ST_READ;
                    if (mt.hf0)                   pn.reset = 1'b1;
                    else if (mt.haa && mt.at_555) st_nxt   = ST_ERS2;
                end
            end
            ST_ERS2: begin
                if (wr_en) begin
                    st_nxt = ST_READ;
                    if (mt.hf0)                   pn.reset = 1'b1;
                    else if (mt.h55 && mt.at_aaa) st_nxt   = ST_ERS3;
                end
            end
            ST_ERS3: begin
                if (wr_en) begin
                    st_nxt = ST_READ;
                    if (mt.hf0) begin
                        pn.reset = 1'b1;
                    end else if (mt.h10 && mt.at_555) begin
                        pn.bulk_erase = 1'b1;
                        st_nxt        = ST_ERASING;
                    end else if (mt.h30 && sect_any) begin
                        mask_load = 1'b1;
                        win_clear = 1'b1;
                        st_nxt    = ST_WINDOW;
                    end
                end
            end
            ST_WINDOW: begin
                if (wr_en && mt.h30 && sect_any) begin
                    mask_or   = 1'b1;
                    win_clear = 1'b1;
                end else if (win_exp) begin
                    pn.sect_erase = 1'b1;
                    st_nxt        = ST_ERASING;
                end
            end
            ST_ERASING: begin
                if (erase_done) begin
                    st_nxt = ST_READ;
                end else if (wr_en && mt.hb0 && !bulk_q) begin
                    pn.suspend = 1'b1;
                    st_nxt     = ST_SUSP;
                end
            end
            ST_SUSP: begin
                if (wr_en && mt.h30) begin
                    pn.resume = 1'b1;
                    st_nxt    = ST_ERASING;
                end
            end
            ST_IDENT: begin
                if (wr_en && mt.hf0) begin
                    pn.reset = 1'b1;
                    st_nxt   = ST_READ;
                end
            end
            ST_BYP: begin
                if (wr_en) begin
                    if (mt.ha0)      st_nxt = ST_BYP_ARM;
                    else if (mt.h90) st_nxt = ST_BYP_EXIT;
                end
            end
            ST_BYP_ARM: begin
                if (wr_en) begin
                    pn.prog = 1'b1;
                    st_nxt  = ST_BYP;
                end
            end
            ST_BYP_EXIT: begin
                if (wr_en) begin
                    if (mt.h00) begin
                        pn.byp_exit = 1'b1;
                        st_nxt      = ST_READ;
                    end else begin
                        st_nxt = ST_BYP;
                    end
                end
            end
            default: st_nxt = ST_READ;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_READ;
        else        st_q <= st_nxt;
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pulse_q <= '0;
            paddr_q <= '0;
            pdata_q <= '0;
            mask_q  <= '0;
            bulk_q  <= 1'b0;
        end else begin
            pulse_q <= pn;
            if (pn.prog) begin
                paddr_q <= wr_addr;
                pdata_q <= wr_data;
            end
            if (mask_load)    mask_q <= sect_sel;
            else if (mask_or) mask_q <= mask_q | sect_sel;
            if (pn.bulk_erase)  bulk_q <= 1'b1;
            else if (mask_load) bulk_q <= 1'b0;
        end
    end

    always_comb begin
        unique case (st_q)
            ST_IDENT:                         mode_e = MODE_IDENT;
            ST_BYP, ST_BYP_ARM, ST_BYP_EXIT:  mode_e = MODE_BYPASS;
            ST_WINDOW, ST_ERASING:            mode_e = MODE_ERASE;
            ST_SUSP:                          mode_e = MODE_SUSP;
            default:                          mode_e = MODE_READ;
        endcase
    end

    assign mode          = mode_e;
    assign busy          = (st_q == ST_ERASING) || (st_q == ST_SUSP);
    assign id_enter_p    = pulse_q.id_enter;
    assign prog_p        = pulse_q.prog;
    assign sect_erase_p  = pulse_q.sect_erase;
    assign bulk_erase_p  = pulse_q.bulk_erase;
    assign suspend_p     = pulse_q.suspend;
    assign resume_p      = pulse_q.resume;
    assign reset_p       = pulse_q.reset;
    assign byp_enter_p   = pulse_q.byp_enter;
    assign byp_exit_p    = pulse_q.byp_exit;
    assign prog_addr     = paddr_q;
    assign prog_data     = pdata_q;
    assign erase_sectors = mask_q;

endmodule

// File: rtl/fcd_checker.sv
module fcd_checker #(
    parameter int N_SECT = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              erase_done,
    input logic [1:0]        rd_sel,
    input logic              id_enter_p,
    input logic              prog_p,
    input logic              sect_erase_p,
    input logic [N_SECT-1:0] erase_sectors,
    input logic              bulk_erase_p,
    input logic              suspend_p,
    input logic              resume_p,
    input logic              reset_p,
    input logic              byp_enter_p,
    input logic              byp_exit_p,
    input logic [2:0]        mode,
    input logic              busy
);

    logic [8:0] pv;
    logic       wr_pulse;

    assign pv = {id_enter_p, prog_p, sect_erase_p, bulk_erase_p, suspend_p,
                 resume_p, reset_p, byp_enter_p, byp_exit_p};
    assign wr_pulse = id_enter_p | prog_p | bulk_erase_p | suspend_p |
                      resume_p | reset_p | byp_enter_p | byp_exit_p;

    // R13
    one_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pv));

    // R13
    pulse_from_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pulse |-> $past(wr_en));

    // R8
    busy_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(erase_done));

    // R7
    sect_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sect_erase_p |-> (erase_sectors != '0) && busy);

    // R3
    rdsel_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel != 2'd0) |-> (mode == 3'd1));

    // R9
    suspend_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        suspend_p |-> (mode == 3'd4));

    // R10
    reset_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reset_p |-> (mode == 3'd0) && !busy);

    // R11
    bypass_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byp_enter_p |-> (mode == 3'd2));

endmodule

bind flash_cmd_decoder fcd_checker #(.N_SECT(N_SECT)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .erase_done    (erase_done),
    .rd_sel        (rd_sel),
    .id_enter_p    (id_enter_p),
    .prog_p        (prog_p),
    .sect_erase_p  (sect_erase_p),
    .erase_sectors (erase_sectors),
    .bulk_erase_p  (bulk_erase_p),
    .suspend_p     (suspend_p),
    .resume_p      (resume_p),
    .reset_p       (reset_p),
    .byp_enter_p   (byp_enter_p),
    .byp_exit_p    (byp_exit_p),
    .mode          (mode),
    .busy          (busy)
);

// File: tb/sim_flash_cmd_decoder.sv
`timescale 1ns/1ps
module sim_flash_cmd_decoder;

    localparam int AW  = 18;
    localparam int NS  = 8;
    localparam int WIN = 16;

    localparam logic [8:0] P_ID   = 9'h100;
    localparam logic [8:0] P_PROG = 9'h080;
    localparam logic [8:0] P_SECT = 9'h040;
    localparam logic [8:0] P_BULK = 9'h020;
    localparam logic [8:0] P_SUSP = 9'h010;
    localparam logic [8:0] P_RES  = 9'h008;
    localparam logic [8:0] P_RST  = 9'h004;
    localparam logic [8:0] P_BEN  = 9'h002;
    localparam logic [8:0] P_BEX  = 9'h001;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0]    wr_data = '0;
    logic [NS-1:0] sect_sel = '0;
    logic          erase_done = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [1:0]    rd_sel;
    logic          id_enter_p, prog_p, sect_erase_p, bulk_erase_p;
    logic          suspend_p, resume_p, reset_p, byp_enter_p, byp_exit_p;
    logic [AW-1:0] prog_addr;
    logic [7:0]    prog_data;
    logic [NS-1:0] erase_sectors;
    logic [2:0]    mode;
    logic          busy;
    logic [8:0]    pv, cap;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;
    int  m_st    = 0;

    always #2 clk = ~clk;

    flash_cmd_decoder #(.ADDR_W(AW), .DEC_W(12), .N_SECT(NS), .WIN_CYC(WIN)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .sect_sel(sect_sel), .erase_done(erase_done),
        .rd_addr(rd_addr), .rd_sel(rd_sel), .id_enter_p(id_enter_p),
        .prog_p(prog_p), .prog_addr(prog_addr), .prog_data(prog_data),
        .sect_erase_p(sect_erase_p), .erase_sectors(erase_sectors),
        .bulk_erase_p(bulk_erase_p), .suspend_p(suspend_p),
        .resume_p(resume_p), .reset_p(reset_p), .byp_enter_p(byp_enter_p),
        .byp_exit_p(byp_exit_p), .mode(mode), .busy(busy)
    );

    assign pv = {id_enter_p, prog_p, sect_erase_p, bulk_erase_p, suspend_p,
                 resume_p, reset_p, byp_enter_p, byp_exit_p};

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
        n_tests++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d, input logic [NS-1:0] s);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d; sect_sel = s;
        @(posedge clk);
        #1;
        cap = pv;
        wr_en = 1'b0; sect_sel = '0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
            chk("R7 window quiet", {23'd0, pv}, 32'd0);
        end
    endtask

    task automatic unlock();
        wr(18'h00555, 8'hAA, '0);
        wr(18'h00AAA, 8'h55, '0);
    endtask

    task automatic erase_prefix();
        unlock();
        wr(18'h00555, 8'h80, '0);
        unlock();
    endtask

    // Bench model of read, identifier, bypass and program paths
    task automatic model(input logic [AW-1:0] a, input logic [7:0] d,
                         output logic [8:0] e, output logic [2:0] md);
        logic [11:0] lo;
        lo = a[11:0];
        e  = '0;
        case (m_st)
            0: if (d == 8'hF0) e = P_RST;
               else if (d == 8'hAA && lo == 12'h555) m_st = 1;
            1: begin
                if (d == 8'hF0) begin e = P_RST; m_st = 0; end
                else if (d == 8'h55 && lo == 12'hAAA) m_st = 2;
                else m_st = 0;
            end
            2: begin
                m_st = 0;
                if (d == 8'hF0) e = P_RST;
                else if (lo == 12'h555) begin
                    if (d == 8'h90)      begin e = P_ID;  m_st = 4; end
                    else if (d == 8'hA0) m_st = 3;
                    else if (d == 8'h20) begin e = P_BEN; m_st = 5; end
                end
            end
            3: begin e = P_PROG; m_st = 0; end
            4: if (d == 8'hF0) begin e = P_RST; m_st = 0; end
            5: if (d == 8'hA0) m_st = 6;
               else if (d == 8'h90) m_st = 7;
            6: begin e = P_PROG; m_st = 5; end
            7: if (d == 8'h00) begin e = P_BEX; m_st = 0; end
               else m_st = 5;
            default: m_st = 0;
        endcase
        md = (m_st == 4) ? 3'd1 : (m_st >= 5) ? 3'd2 : 3'd0;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [8:0]    ev;
        logic [2:0]    em;
        logic [AW-1:0] ra;
        logic [7:0]    rdv;
        int            seed_v;
        seed_v = $urandom(32'h5EED);

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R13 reset pulses", {23'd0, pv}, 32'd0);
        chk("R8 reset mode", {29'd0, mode}, 32'd0);
        chk("R8 reset busy", {31'd0, busy}, 32'd0);

        // R3 identifier entry and read select
        unlock();
        chk("R1 no pulse during unlock", {23'd0, cap}, 32'd0);
        wr(18'h00555, 8'h90, '0);
        chk("R3 id pulse", {23'd0, cap}, {23'd0, P_ID});
        chk("R3 id mode", {29'd0, mode}, 32'd1);
        rd_addr = 18'h20001; #1;
        chk("R3 devid select", {30'd0, rd_sel}, 32'd1);
        rd_addr = 18'h00002; #1;
        chk("R3 prot select", {30'd0, rd_sel}, 32'd2);
        rd_addr = 18'h00042; #1;
        chk("R3 A6 set gives array", {30'd0, rd_sel}, 32'd0);
        rd_addr = 18'h00003; #1;
        chk("R3 other gives array", {30'd0, rd_sel}, 32'd0);
        wr(18'h00555, 8'hAA, '0);
        chk("R3 write ignored in id", {23'd0, cap}, 32'd0);
        chk("R3 still id", {29'd0, mode}, 32'd1);
        wr(18'h00123, 8'hF0, '0);
        chk("R10 reset from id", {23'd0, cap}, {23'd0, P_RST});
        rd_addr = 18'h00001; #1;
        chk("R3 select off outside id", {30'd0, rd_sel}, 32'd0);

        // R1 abort on wrong address
        wr(18'h00555, 8'hAA, '0);
        wr(18'h00555, 8'h55, '0);
        wr(18'h00555, 8'h90, '0);
        chk("R1 broken unlock gives no pulse", {23'd0, cap}, 32'd0);
        chk("R1 broken unlock mode", {29'd0, mode}, 32'd0);

        // R4 program
        unlock();
        wr(18'h00555, 8'hA0, '0);
        chk("R4 arm no pulse", {23'd0, cap}, 32'd0);
        wr(18'h31234, 8'h5A, '0);
        chk("R4 prog pulse", {23'd0, cap}, {23'd0, P_PROG});
        chk("R4 prog addr", {14'd0, prog_addr}, 32'h31234);
        chk("R4 prog data", {24'd0, prog_data}, 32'h5A);

        // R2 upper address bits ignored
        wr(18'h3F555, 8'hAA, '0);
        wr(18'h2CAAA, 8'h55, '0);
        wr(18'h10555, 8'h90, '0);
        chk("R2 upper bits ignored", {23'd0, cap}, {23'd0, P_ID});
        wr(18'h00000, 8'hF0, '0);

        // R10 reset in mid sequence
        wr(18'h00555, 8'hAA, '0);
        wr(18'h00AAA, 8'hF0, '0);
        chk("R10 reset mid sequence", {23'd0, cap}, {23'd0, P_RST});

        // R11 / R12 bypass
        unlock();
        wr(18'h00555, 8'h20, '0);
        chk("R11 bypass pulse", {23'd0, cap}, {23'd0, P_BEN});
        chk("R11 bypass mode", {29'd0, mode}, 32'd2);
        wr(18'h00777, 8'hA0, '0);
        wr(18'h00100, 8'h3C, '0);
        chk("R11 bypass prog", {23'd0, cap}, {23'd0, P_PROG});
        chk("R11 bypass prog data", {24'd0, prog_data}, 32'h3C);
        wr(18'h00555, 8'hF0, '0);
        chk("R10 no reset in bypass", {23'd0, cap}, 32'd0);
        chk("R12 still bypass", {29'd0, mode}, 32'd2);
        wr(18'h00010, 8'h90, '0);
        wr(18'h00010, 8'h55, '0);
        chk("R12 bad exit stays", {29'd0, mode}, 32'd2);
        wr(18'h00011, 8'h90, '0);
        wr(18'h00022, 8'h00, '0);
        chk("R12 exit pulse", {23'd0, cap}, {23'd0, P_BEX});
        chk("R12 exit mode", {29'd0, mode}, 32'd0);

        // R6 no sector selected
        erase_prefix();
        wr(18'h04000, 8'h30, '0);
        chk("R6 no sector no pulse", {23'd0, cap}, 32'd0);
        chk("R6 no sector mode", {29'd0, mode}, 32'd0);
        idle(WIN + 2);
        chk("R6 not busy", {31'd0, busy}, 32'd0);

        // R7 single sector window, exact timing
        erase_prefix();
        wr(18'h04000, 8'h30, 8'h01);
        chk("R7 window mode", {29'd0, mode}, 32'd3);
        chk("R7 window not busy", {31'd0, busy}, 32'd0);
        for (int i = 1; i <= WIN; i++) begin
            @(posedge clk); #1;
            chk("R7 expiry timing", {23'd0, pv}, (i == WIN) ? {23'd0, P_SECT} : 32'd0);
        end
        chk("R7 mask single", {24'd0, erase_sectors}, 32'h01);
        chk("R8 busy after erase", {31'd0, busy}, 32'd1);
        wr(18'h00000, 8'hB0, '0);
        chk("R9 suspend pulse", {23'd0, cap}, {23'd0, P_SUSP});
        chk("R9 suspend mode", {29'd0, mode}, 32'd4);
        wr(18'h00000, 8'h30, '0);
        chk("R9 resume pulse", {23'd0, cap}, {23'd0, P_RES});
        chk("R9 resume mode", {29'd0, mode}, 32'd3);
        @(negedge clk); erase_done = 1'b1;
        @(posedge clk); #1; erase_done = 1'b0;
        chk("R8 done clears busy", {31'd0, busy}, 32'd0);
        chk("R8 done mode", {29'd0, mode}, 32'd0);

        // R7 added sector and ignored write restart the window
        erase_prefix();
        wr(18'h04000, 8'h30, 8'h01);
        idle(3);
        wr(18'h00555, 8'hF0, '0);
        chk("R7 other write ignored", {23'd0, cap}, 32'd0);
        wr(18'h0C000, 8'h30, 8'h04);
        for (int i = 1; i <= WIN; i++) begin
            @(posedge clk); #1;
            chk("R7 restart timing", {23'd0, pv}, (i == WIN) ? {23'd0, P_SECT} : 32'd0);
        end
        chk("R7 mask merged", {24'd0, erase_sectors}, 32'h05);
        @(negedge clk); erase_done = 1'b1;
        @(posedge clk); #1; erase_done = 1'b0;

        // R5 bulk erase; R9 suspend ignored
        erase_prefix();
        wr(18'h00555, 8'h10, '0);
        chk("R5 bulk pulse", {23'd0, cap}, {23'd0, P_BULK});
        chk("R5 bulk busy", {31'd0, busy}, 32'd1);
        wr(18'h00000, 8'hB0, '0);
        chk("R9 no suspend in bulk", {23'd0, cap}, 32'd0);
        chk("R9 bulk mode kept", {29'd0, mode}, 32'd3);
        @(negedge clk); erase_done = 1'b1;
        @(posedge clk); #1; erase_done = 1'b0;
        chk("R8 bulk done", {29'd0, mode}, 32'd0);

        // Random stream against bench model
        m_st = 0;
        for (int n = 0; n < 3000; n++) begin
            int k;
            k   = $urandom % 12;
            ra  = AW'($urandom);
            rdv = 8'($urandom);
            if (rdv == 8'h80) rdv = 8'h81;
            case (k)
                0:  begin ra[11:0] = 12'h555; rdv = 8'hAA; end
                1:  begin ra[11:0] = 12'hAAA; rdv = 8'h55; end
                2:  begin ra[11:0] = 12'h555; rdv = 8'h90; end
                3:  begin ra[11:0] = 12'h555; rdv = 8'hA0; end
                4:  begin ra[11:0] = 12'h555; rdv = 8'h20; end
                5:  rdv = 8'hF0;
                6:  rdv = 8'h90;
                7:  rdv = 8'h00;
                8:  rdv = 8'hA0;
                10: begin ra[11:0] = 12'hAAA; rdv = 8'hAA; end
                11: begin ra[11:0] = 12'h555; rdv = 8'h55; end
                default: ;
            endcase
            model(ra, rdv, ev, em);
            wr(ra, rdv, 8'($urandom));
            chk("R13 random pulse", {23'd0, cap}, {23'd0, ev});
            chk("R1 random mode", {29'd0, mode}, {29'd0, em});
            if (ev == P_PROG) begin
                chk("R4 random prog addr", {14'd0, prog_addr}, {14'd0, ra});
                chk("R4 random prog data", {24'd0, prog_data}, {24'd0, rdv});
            end
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule